// File: doc/BRIEF.md
# Leftmost-One Race Magnitude Comparator

This block compares two unsigned operands of equal width in a single combinational pass. Rather than subtract, it first turns the operands into two difference buses. The first bus marks every position where operand `a` holds a one and operand `b` holds a zero. The second bus marks the reverse case. The two buses never overlap. The bus that holds the highest set bit belongs to the larger operand.

Both buses are cut into 8-bit slices. Each slice reports two things: whether it holds any difference, and which bus owns its highest set bit. A priority multiplexer then takes the answer from the most significant slice that holds a difference. When no slice holds a difference, the operands are equal. The three result lines are mutually exclusive, so downstream logic can use them directly as a sort key or a branch condition.

Top module: `lmo_cmp`

## Requirements
- R1: When `a` equals `b`, `eq` is 1 and both `lt` and `gt` are 0.
- R2: When `a` is greater than `b` as unsigned numbers, `gt` is 1, and `eq` and `lt` are 0.
- R3: When `a` is less than `b` as unsigned numbers, `lt` is 1, and `eq` and `gt` are 0.
- R4: Exactly one of `eq`, `lt` and `gt` is 1 for every input pair.
- R5: The result depends only on the most significant bit position where the operands differ. Differences at lower positions that point the opposite way have no effect on the outputs.
- R6: A difference decides the result correctly at any position. This includes bit 0, the top bit W-1, and the bits on either side of every 8-bit slice boundary (bits 8k-1 and 8k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| eq | output | 1 | Operands are equal |
| lt | output | 1 | `a` is less than `b` |
| gt | output | 1 | `a` is greater than `b` |

## Verification
The hardest case to reach is the one where several slices hold differences that point in opposite directions. Only the top active slice may decide the result, and uniform random operands almost always differ in the top slice. To reach this case, the stimulus copies `a` into `b` and then plants one decisive difference at a chosen position. It then flips bits below that position in the opposite direction, either in lower slices or in the same slice. A sweep places the single decisive difference on every bit, which covers each slice boundary and both ends of the word.

// File: rtl/lmo_cmp.sv
module lmo_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         lt,
  output logic         gt
);
  localparam int NBLK = W / 8;

  logic [W-1:0]    lbus, rbus;
  logic [NBLK-1:0] blk_act, blk_win;
  logic            any_act, sel_win;

  assign lbus = a & ~b;
  assign rbus = ~a & b;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    logic [7:0] l8, r8;
    logic       w;
    assign l8 = lbus[8*k +: 8];
    assign r8 = rbus[8*k +: 8];
    always_comb begin
      w = 1'b0;
      for (int i = 0; i < 8; i++)
        if (l8[i] | r8[i]) w = l8[i];
    end
    assign blk_act[k] = |(l8 | r8);
    assign blk_win[k] = w;
  end

  always_comb begin
    sel_win = 1'b0;
    for (int k = 0; k < NBLK; k++)
      if (blk_act[k]) sel_win = blk_win[k];
  end

  assign any_act = |blk_act;
  assign eq = ~any_act;
  assign gt = any_act & sel_win;
  assign lt = any_act & ~sel_win;
endmodule

// File: rtl/lmo_cmp_chk.sv
module lmo_cmp_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         eq,
  input logic         lt,
  input logic         gt
);
  always_comb begin
    // R4
    one_result_chk: assert ($countones({eq, lt, gt}) == 1);
    // R1
    eq_match_chk: assert (eq == (a == b));
    // R2
    gt_match_chk: assert (!gt || (a > b));
    // R3
    lt_match_chk: assert (!lt || (a < b));
  end
endmodule

bind lmo_cmp lmo_cmp_chk #(.W(W)) u_chk (.a(a), .b(b), .eq(eq), .lt(lt), .gt(gt));

// File: tb/lmo_cmp_tb.sv
module lmo_cmp_tb;
  localparam int W = 32;
  logic clk = 1'b0;
  logic [W-1:0] a, b;
  logic eq, lt, gt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lmo_cmp #(.W(W)) u_dut (.a(a), .b(b), .eq(eq), .lt(lt), .gt(gt));

  function automatic logic [2:0] expect_of(logic [W-1:0] x, logic [W-1:0] y);
    logic [2:0] r;
    r = 3'b100;
    for (int i = 0; i < W; i++)
      if (x[i] != y[i]) r = x[i] ? 3'b001 : 3'b010;
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    logic [2:0] e;
    @(negedge clk);
    a = x; b = y;
    #1;
    e = expect_of(x, y);
    checks++;
    if ({eq, lt, gt} !== e) begin
      errors++;
      $display("FAIL %s a=%h b=%h got eq/lt/gt=%b exp=%b", req, x, y, {eq, lt, gt}, e);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] x, y;
    void'($urandom(32'd12345));
    apply('0, '0, "R1 zero");
    apply('1, '1, "R1 ones");
    apply('1, '0, "R2 ones vs zero");
    apply('0, '1, "R3 zero vs ones");
    for (int p = 0; p < W; p++) begin
      x = $urandom;
      y = x; y[p] = 1'b0; x[p] = 1'b1;
      apply(x, y, "R6 R2 single bit");
      apply(y, x, "R6 R3 single bit");
    end
    for (int n = 0; n < 300; n++) begin
      int p;
      p = 1 + ($urandom % (W - 1));
      x = $urandom;
      y = x; x[p] = 1'b1; y[p] = 1'b0;
      for (int i = 0; i < p; i++)
        if ($urandom % 2 == 1) begin x[i] = 1'b0; y[i] = 1'b1; end
      apply(x, y, "R5 R2 opposite lower");
      apply(y, x, "R5 R3 opposite lower");
    end
    for (int n = 0; n < 300; n++) begin
      x = $urandom; y = $urandom;
      apply(x, y, "R4 random");
      apply(x, x, "R1 random equal");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule